// File: doc/BRIEF.md
# Carry-Bypass Group Adder

This block adds two N-bit operands and a carry-in, giving an N-bit sum and a carry-out. The operand width is cut into equal slices of M bits. Each slice ripples its carry from its lowest bit to its highest bit. Each slice also ANDs together its per-bit propagate terms. When that AND is true, a multiplexer hands the slice's incoming carry straight to the next slice, so the carry does not have to wait for the ripple. When the AND is false, the slice's own ripple carry goes on instead.

The adding logic is purely combinational. The top level places it behind one rank of output registers that clear on a synchronous active-high reset, so the arithmetic can be driven and observed cycle by cycle. The defaults are a 16-bit width built from four slices of 4 bits.

Top module: `cba_adder`

## Requirements
- R1: The operand width N is divided into N/M slices of M bits each, covering bits [M*i+M-1 : M*i] for slice i. A width that is not a whole multiple of M, or M below 1, is rejected at elaboration.
- R2: For each bit k, the propagate term is a[k] XOR b[k] and the generate term is a[k] AND b[k].
- R3: Inside a slice the carry out of bit k is generate_k OR (propagate_k AND carry into bit k). Sum bit k is propagate_k XOR (carry into bit k). The carry into the lowest bit of a slice is that slice's incoming carry.
- R4: A slice whose M propagate terms are all 1 passes its incoming carry to its carry-out, and every one of its sum bits is the inverse of that incoming carry.
- R5: A slice with at least one propagate term equal to 0 takes its carry-out from its own ripple chain. That carry-out is then the same for carry-in 0 and carry-in 1.
- R6: {carry_out, sum} equals op_a + op_b + carry_in, computed as an (N+1)-bit unsigned sum.
- R7: The outputs sum_q and carry_out_q show the result for the operands present at the previous rising clock edge, one cycle of latency.
- R8: While rst is high at a rising edge, sum_q and carry_out_q are cleared to 0 at that edge.
- R9: The defaults are N = 16 and M = 4, giving four slices over bits 0-3, 4-7, 8-11 and 12-15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output registers |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | N | Registered sum |
| carry_out_q | output | 1 | Registered carry out of bit N-1 |

## Verification
The combinational assertions assume that the operands and the carry-in hold known 0/1 values whenever they are evaluated. The bench keeps to this by driving every input from reset onward and changing the inputs only at the falling edge. The registered-result assertion assumes that the inputs stay stable around each rising edge, which the same scheme guarantees. The stimulus includes operand pairs that make whole slices propagate, such as all-ones plus a carry-in and alternating patterns, so that the bypass path is exercised as well as the ripple path.

// File: rtl/cba_pkg.sv
package cba_pkg;

  typedef struct packed {
    logic prop;
    logic gen;
  } cba_pg_t;

  function automatic int unsigned cba_slices(input int unsigned width, input int unsigned slice);
    return width / slice;
  endfunction

endpackage

// File: rtl/cba_pg_cell.sv
module cba_pg_cell
  import cba_pkg::*;
(
  input  logic    bit_a,
  input  logic    bit_b,
  output cba_pg_t pg
);

  // R2: propagate is exclusive-or, generate is and
  always_comb begin
    pg.prop = bit_a ^ bit_b;
    pg.gen  = bit_a & bit_b;
  end

endmodule

// File: rtl/cba_group.sv
module cba_group
  import cba_pkg::*;
#(
  parameter int unsigned M = 4
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  input  logic         cin,
  output logic [M-1:0] sum,
  output logic         cout
);

  cba_pg_t [M-1:0] pg;
  logic    [M:0]   chain;
  logic    [M-1:0] prop_vec;
  logic            skip;

  assign chain[0] = cin;

  for (genvar k = 0; k < M; k++) begin : g_bit
    cba_pg_cell u_pg (
      .bit_a (a[k]),
      .bit_b (b[k]),
      .pg    (pg[k])
    );
    assign prop_vec[k]  = pg[k].prop;
    // R3: ripple step and sum bit
    assign chain[k+1]   = pg[k].gen | (pg[k].prop & chain[k]);
    assign sum[k]       = pg[k].prop ^ chain[k];
  end

  // R4 / R5: bypass select
  assign skip = &prop_vec;
  assign cout = skip ? cin : chain[M];

  always_comb begin
    if (skip) begin
      p_bypass_sum_r4: assert (sum == {M{~cin}});
    end
    p_slice_arith_r6: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (M+1)'(cin)));
  end

endmodule

// File: rtl/cba_core.sv
module cba_core
  import cba_pkg::*;
#(
  parameter int unsigned N = 16,
  parameter int unsigned M = 4
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);

  localparam int unsigned SLICES = cba_slices(N, M);

  // R1: elaboration-time shape check
  if (M < 1 || (N % M) != 0) begin : g_bad_shape
    $error("cba_core: width %0d is not a whole number of %0d-bit slices", N, M);
  end

  logic [SLICES:0] link;
  assign link[0] = cin;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    cba_group #(.M(M)) u_slice (
      .a    (a[s*M +: M]),
      .b    (b[s*M +: M]),
      .cin  (link[s]),
      .sum  (sum[s*M +: M]),
      .cout (link[s+1])
    );
  end

  assign cout = link[SLICES];

  always_comb begin
    p_full_sum_r6: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (N+1)'(cin)));
  end

endmodule

// File: rtl/cba_adder.sv
module cba_adder #(
  parameter int unsigned N = 16,
  parameter int unsigned M = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         carry_in,
  output logic [N-1:0] sum_q,
  output logic         carry_out_q
);

  logic [N-1:0] sum_c;
  logic         cout_c;

  cba_core #(.N(N), .M(M)) u_core (
    .a    (op_a),
    .b    (op_b),
    .cin  (carry_in),
    .sum  (sum_c),
    .cout (cout_c)
  );

  // R7 / R8: output register with synchronous clear
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q       <= '0;
      carry_out_q <= 1'b0;
    end else begin
      sum_q       <= sum_c;
      carry_out_q <= cout_c;
    end
  end

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_q == '0 && carry_out_q == 1'b0));

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({carry_out_q, sum_q} ==
      ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + (N+1)'($past(carry_in)))));

  p_zero_operands_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_a) == '0 && $past(op_b) == '0) |-> (sum_q == N'($past(carry_in)) && !carry_out_q));

endmodule

// File: tb/cba_adder_tb.sv
module cba_adder_tb;

  localparam int N = 16;
  localparam int M = 4;
  localparam int NV = 15;

  // stimulus {a, b, cin} and expected {cout, sum}
  localparam logic [32:0] STIM [NV] = '{
    {16'h0000, 16'h0000, 1'b0},  // R9 all zero
    {16'hFFFF, 16'h0000, 1'b1},  // R4 every slice bypasses
    {16'hFFFF, 16'hFFFF, 1'b1},  // R3 every slice generates
    {16'hAAAA, 16'h5555, 1'b0},  // R4 alternating, carry-in 0
    {16'hAAAA, 16'h5555, 1'b1},  // R4 alternating, carry-in 1
    {16'h1234, 16'h4321, 1'b0},  // R2 no carries
    {16'h8000, 16'h8000, 1'b0},  // R3 top bit generates
    {16'h0F0F, 16'h00F1, 1'b0},  // R3 ripple into slice 2
    {16'h00FF, 16'h0001, 1'b0},  // R4 bypass of slice 1
    {16'hFFFF, 16'h0001, 1'b0},  // R4 long chain of bypasses
    {16'h7FFF, 16'h0001, 1'b0},  // R5 top slice ripples
    {16'hFFF0, 16'h000F, 1'b1},  // R4 propagate everywhere
    {16'h000F, 16'h0001, 1'b0},  // R1 carry across the bit 3/4 boundary
    {16'h8FFF, 16'h8000, 1'b0},  // R5 top slice generates
    {16'h8FFF, 16'h8000, 1'b1}   // R5 same, carry-in 1
  };
  localparam logic [16:0] EXPV [NV] = '{
    17'h0_0000, 17'h1_0000, 17'h1_FFFF, 17'h0_FFFF, 17'h1_0000,
    17'h0_5555, 17'h1_0000, 17'h0_1000, 17'h0_0100, 17'h1_0000,
    17'h0_8000, 17'h1_0000, 17'h0_0010, 17'h1_0FFF, 17'h1_1000
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] op_a = '0;
  logic [N-1:0] op_b = '0;
  logic         carry_in = 1'b0;
  logic [N-1:0] sum_q;
  logic         carry_out_q;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cba_adder #(.N(N), .M(M)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .op_a        (op_a),
    .op_b        (op_b),
    .carry_in    (carry_in),
    .sum_q       (sum_q),
    .carry_out_q (carry_out_q)
  );

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] want);
    n_checks++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b, input logic c);
    @(negedge clk);
    op_a = a;
    op_b = b;
    carry_in = c;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] seed;
    logic        c_first;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R8 reset state", {carry_out_q, sum_q}, 17'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(STIM[i][32:17], STIM[i][16:1], STIM[i][0]);
      check("R6 table", {carry_out_q, sum_q}, EXPV[i]);
    end

    // R5: top slice not propagating, carry-out same for both carry-in values
    apply(16'h0FFF, 16'h0000, 1'b0);
    c_first = carry_out_q;
    apply(16'h0FFF, 16'h0000, 1'b1);
    check("R5 carry-in independence", {16'h0, carry_out_q}, {16'h0, c_first});

    // R4: bypassed slices give inverted carry-in on every sum bit
    apply(16'hF0F0, 16'h0F0F, 1'b1);
    check("R4 bypass sum", {carry_out_q, sum_q}, 17'h1_0000);

    // R7: one cycle latency, output follows previous edge only
    @(negedge clk);
    op_a = 16'h0001; op_b = 16'h0001; carry_in = 1'b0;
    @(posedge clk);
    #1;
    check("R7 latency", {carry_out_q, sum_q}, 17'h0_0002);

    // R6: pseudo-random operands against behavioural sum
    for (int i = 0; i < 200; i++) begin
      logic [N-1:0] ra, rb;
      logic         rc;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      ra = seed[15:0]; rb = seed[31:16]; rc = seed[7];
      apply(ra, rb, rc);
      check("R6 random", {carry_out_q, sum_q}, {1'b0, ra} + {1'b0, rb} + 17'(rc));
    end

    // R8: synchronous clear from a non-zero result
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R8 clear", {carry_out_q, sum_q}, 17'h0);
    @(negedge clk);
    check("R8 held", {carry_out_q, sum_q}, 17'h0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule